// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block supervises software by counting ticks of one of two clock-enable inputs and acting when a chosen number of ticks has gone by without the counter being cleared. In supervision mode the block sets its flag and sends a one-cycle system reset request when that count is reached. In interval mode the flag is set instead, and the count keeps running so that the flag comes back every period. An interrupt is raised from the flag when both a local enable and a global enable are high.

Software reaches the block through one 16-bit control word. Every write must carry the key 0x5A in its upper byte. A write with any other upper byte changes nothing and forces a reset request, which catches stray or corrupted accesses. Reads show a different fixed key, 0x69, in the upper byte, so a read value written back as is counts as a bad write. After any reset request the block restarts itself in its safest setting: supervision, longest period, counter at zero.

Top module: `wdog_timer`

## Requirements
- R1: A write with upper byte 0x5A loads the configuration from the lower byte. A write with any other upper byte leaves the configuration alone and causes `rst_req` to be high for exactly the cycle after the write.
- R2: `rd_data` is always {0x69, hold, nmi_edge, nmi_func, mode, 0, src, sel[1:0]}, with hold at bit 7, the two pin-configuration bits at 6 and 5, mode at bit 4, src at bit 2 and sel at bits 1:0.
- R3: While hold (bit 7) is 1, the counter does not advance.
- R4: Writing bit 3 = 1 with a valid key sets the counter to zero. The bit is not stored and always reads as 0.
- R5: src (bit 2) picks the tick that is counted: 0 counts `tick_sub`, 1 counts `tick_aux`. The other tick has no effect.
- R6: sel picks the period N in counted ticks after a clear: 00 gives 32768, 01 gives 8192, 10 gives 512, 11 gives 64. Expiry happens on the Nth tick.
- R7: In supervision mode (mode = 0), expiry sets `flag` and makes `rst_req` high for one cycle.
- R8: In interval mode (mode = 1), expiry sets `flag` without a reset request, and the count goes on, so the next expiry comes N ticks later.
- R9: `irq` is high exactly when `flag`, mode = 1, `irq_en` and `glob_en` are all 1.
- R10: `irq_ack` clears `flag` in interval mode only. `flag_clr` clears it in either mode. An expiry in the same cycle wins over either clear.
- R11: In the cycle where `rst_req` is high, the configuration reads 0x00 (supervision, `tick_sub`, period 32768, not held) and the counter is zero. `flag` keeps its value.
- R12: Bits 6 and 5 are stored and read back, and they have no effect on counting, expiry or outputs.
- R13: A synchronous active-low `rst_n` clears the configuration, the counter, `flag` and `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data: key in upper byte, configuration in lower byte |
| rd_data | output | 16 | Read key and current configuration |
| tick_sub | input | 1 | Subsystem clock enable, counted when src = 0 |
| tick_aux | input | 1 | Auxiliary clock enable, counted when src = 1 |
| irq_en | input | 1 | Local interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced; clears flag in interval mode |
| flag_clr | input | 1 | Software flag clear |
| irq | output | 1 | Interval interrupt request |
| flag | output | 1 | Expiry flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The properties assume that `wr_en` is a single-cycle strobe sampled on the clock edge. They also assume the tick inputs are synchronous to `clk`, and that nothing forces the counter's state apart from the block's own write and expiry paths. The stimulus follows these rules: all inputs change only a short delay after the rising edge. Random writes carry the valid key most of the time and pick mostly the short periods, so that expiries, bad-key restarts and clears collide often. The directed part walks each period up to its exact boundary tick.

// File: rtl/wdog_pkg.sv
// Shared types and helpers for the keyed watchdog.
// Assumes an 8-bit configuration byte inside a 16-bit control word.
package wdog_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int N_TAPS = 4;

    // Stored configuration (the clear strobe is not stored).
    typedef struct packed {
        logic       hold;
        logic [1:0] pin_cfg;
        logic       ivl_mode;
        logic       src_aux;
        logic [1:0] sel;
    } wd_cfg_t;

    localparam wd_cfg_t CFG_DEFAULT = '0;

    // Bit positions inside the lower byte.
    localparam int B_HOLD = 7;
    localparam int B_MODE = 4;
    localparam int B_CLR  = 3;
    localparam int B_SRC  = 2;

    // Pack the configuration back into the readable lower byte.
    function automatic logic [BYTE_W-1:0] cfg_pack(input wd_cfg_t c);
        return {c.hold, c.pin_cfg, c.ivl_mode, 1'b0, c.src_aux, c.sel};
    endfunction

    // Unpack a written lower byte into the stored configuration.
    function automatic wd_cfg_t cfg_unpack(input logic [BYTE_W-1:0] b);
        wd_cfg_t c;
        c.hold     = b[B_HOLD];
        c.pin_cfg  = b[6:5];
        c.ivl_mode = b[B_MODE];
        c.src_aux  = b[B_SRC];
        c.sel      = b[1:0];
        return c;
    endfunction

    // Number of low counter bits that set the period (period = 2**bits).
    function automatic int tap_bits(input int cnt_w, input int idx);
        case (idx)
            0:       return cnt_w - 1;
            1:       return cnt_w - 3;
            2:       return cnt_w - 7;
            default: return cnt_w - 10;
        endcase
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
// Control register of the keyed watchdog.
// Checks the write key, stores the configuration and makes the clear
// strobe and the read word. A reset request (puc) puts it back to default.
// Assumes wr_en is a one-cycle strobe synchronous to clk.
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter logic [7:0] WR_KEY = 8'h5A,
    parameter logic [7:0] RD_KEY = 8'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             puc,
    output wd_cfg_t          cfg,
    output logic             clr_strobe,
    output logic             key_bad,
    output logic [REG_W-1:0] rd_data
);

    localparam int KEY_LO = REG_W - BYTE_W;

    logic key_ok;

    // Decode the key of the current write.
    always_comb begin
        key_ok     = wr_en && (wr_data[REG_W-1:KEY_LO] == WR_KEY);
        key_bad    = wr_en && (wr_data[REG_W-1:KEY_LO] != WR_KEY);
        clr_strobe = key_ok && wr_data[B_CLR];
    end

    // Hold the configuration; a reset request takes priority over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_DEFAULT;
        end else if (puc) begin
            cfg <= CFG_DEFAULT;
        end else if (key_ok) begin
            cfg <= cfg_unpack(wr_data[BYTE_W-1:0]);
        end
    end

    // Build the read word from the fixed read key and the configuration.
    assign rd_data = {RD_KEY, cfg_pack(cfg)};

endmodule

// File: rtl/wdog_counter.sv
// Tick counter of the keyed watchdog.
// Counts the selected clock enable unless held, and reports an expiry
// on the tick that fills the low bits picked by the interval select.
// Assumes CNT_W >= 11 so that every tap has at least one bit.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sub,
    input  logic             tick_aux,
    input  wd_cfg_t          cfg,
    input  logic             clr_strobe,
    input  logic             puc,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);

    logic              tick_sel;
    logic              run;
    logic [N_TAPS-1:0] tap_full;

    // One detector for each period: all low bits of that tap are set.
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int TB = tap_bits(CNT_W, i);
        assign tap_full[i] = &cnt[TB-1:0];
    end

    // Pick the counted tick and decide whether this cycle ends a period.
    always_comb begin
        tick_sel = cfg.src_aux ? tick_aux : tick_sub;
        run      = tick_sel && !cfg.hold;
        expire   = run && tap_full[cfg.sel];
    end

    // Advance, clear or restart the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (puc || clr_strobe) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_event.sv
// Event logic of the keyed watchdog.
// Turns expiries and bad keys into the flag, the interrupt and the
// one-cycle reset request.
// Assumes expire and key_bad come straight from same-cycle logic.
module wdog_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ivl_mode,
    input  logic key_bad,
    input  logic irq_ack,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic glob_en,
    output logic puc,
    output logic flag,
    output logic irq,
    output logic rst_req
);

    // A reset request comes from a bad key or from an expiry in supervision mode.
    always_comb begin
        puc = key_bad || (expire && !ivl_mode);
        irq = flag && ivl_mode && irq_en && glob_en;
    end

    // Set the flag on expiry; otherwise clear it on a software clear or an interval-mode ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (flag_clr || (irq_ack && ivl_mode)) begin
            flag <= 1'b0;
        end
    end

    // Register the reset request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= puc;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
// Top of the keyed watchdog and interval timer.
// Connects the control register, the tick counter and the event logic.
// Assumes all inputs are synchronous to clk.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int         CNT_W  = 16,
    parameter logic [7:0] WR_KEY = 8'h5A,
    parameter logic [7:0] RD_KEY = 8'h69
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        tick_sub,
    input  logic        tick_aux,
    input  logic        irq_en,
    input  logic        glob_en,
    input  logic        irq_ack,
    input  logic        flag_clr,
    output logic        irq,
    output logic        flag,
    output logic        rst_req
);

    wd_cfg_t          cfg;
    logic             clr_strobe;
    logic             key_bad;
    logic             puc;
    logic             expire;
    logic [CNT_W-1:0] cnt_val;

    wdog_ctrl_reg #(
        .WR_KEY(WR_KEY),
        .RD_KEY(RD_KEY)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .puc       (puc),
        .cfg       (cfg),
        .clr_strobe(clr_strobe),
        .key_bad   (key_bad),
        .rd_data   (rd_data)
    );

    wdog_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_sub  (tick_sub),
        .tick_aux  (tick_aux),
        .cfg       (cfg),
        .clr_strobe(clr_strobe),
        .puc       (puc),
        .expire    (expire),
        .cnt       (cnt_val)
    );

    wdog_event i_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ivl_mode(cfg.ivl_mode),
        .key_bad (key_bad),
        .irq_ack (irq_ack),
        .flag_clr(flag_clr),
        .irq_en  (irq_en),
        .glob_en (glob_en),
        .puc     (puc),
        .flag    (flag),
        .irq     (irq),
        .rst_req (rst_req)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
// Property checker for the keyed watchdog, bound to its top module.
// Watches ports and the counter state; assumes wr_en is a single-cycle strobe.
module wdog_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_data,
    input logic [15:0]      rd_data,
    input logic             irq_en,
    input logic             glob_en,
    input logic             irq,
    input logic             flag,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt
);

    // R1: a write with a wrong key is followed by a reset request
    assert_badkey_rst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] != 8'h5A) |=> rst_req);

    // R2: the upper byte of a read is the read key
    assert_read_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:8] == 8'h69);

    // R4: the clear strobe is never seen in the read word
    assert_clr_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3]);

    // R3: a held counter with no write does not move
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !wr_en) |=> $stable(cnt));

    // R9: an interrupt needs the flag, interval mode and both enables
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && rd_data[4] && irq_en && glob_en));

    // R11: a reset request comes with the default configuration and a zero count
    assert_restart_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rd_data[7:0] == 8'h00 && cnt == '0));

    // R7: a reset request is a one-cycle pulse unless a new cause arrives
    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !wr_en) |=> !rst_req);

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .irq_en (irq_en),
    .glob_en(glob_en),
    .irq    (irq),
    .flag   (flag),
    .rst_req(rst_req),
    .cnt    (cnt_val)
);

// File: tb/test_wdog_timer.sv
// Self-checking bench: directed boundary cases, then random stimulus
// compared each cycle with a reference model written from the requirements.
module test_wdog_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tick_sub = 1'b0, tick_aux = 1'b0;
    logic        irq_en = 1'b0, glob_en = 1'b0, irq_ack = 1'b0, flag_clr = 1'b0;
    logic        irq, flag, rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_sub(tick_sub), .tick_aux(tick_aux),
        .irq_en(irq_en), .glob_en(glob_en), .irq_ack(irq_ack),
        .flag_clr(flag_clr), .irq(irq), .flag(flag), .rst_req(rst_req)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_cfg;
    logic [15:0] m_cnt;
    logic        m_flag, m_rreq;

    function automatic int period_bits(input logic [1:0] sel);
        case (sel)
            2'd0: return 15;
            2'd1: return 13;
            2'd2: return 9;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk) begin
        logic tk, run, hit, bad, good, puc;
        logic [15:0] msk;
        if (!rst_n) begin
            m_cfg <= 8'h00; m_cnt <= '0; m_flag <= 1'b0; m_rreq <= 1'b0;
        end else begin
            tk   = m_cfg[2] ? tick_aux : tick_sub;
            run  = tk && !m_cfg[7];
            msk  = 16'((32'd1 << period_bits(m_cfg[1:0])) - 1);
            hit  = run && ((m_cnt & msk) == msk);
            bad  = wr_en && wr_data[15:8] != 8'h5A;
            good = wr_en && wr_data[15:8] == 8'h5A;
            puc  = bad || (hit && !m_cfg[4]);
            if (hit) m_flag <= 1'b1;
            else if (flag_clr || (irq_ack && m_cfg[4])) m_flag <= 1'b0;
            m_rreq <= puc;
            if (puc) begin
                m_cfg <= 8'h00; m_cnt <= '0;
            end else begin
                if (good) m_cfg <= wr_data[7:0] & 8'hF7;
                if (good && wr_data[3]) m_cnt <= '0;
                else if (run) m_cnt <= m_cnt + 16'd1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, input bit aux);
        tick_sub = !aux; tick_aux = aux;
        repeat (n) cyc();
        tick_sub = 1'b0; tick_aux = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd1234));
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();
        // R13 / R2: reset state
        check("R13 rd_data after reset", rd_data, 16'h6900);
        check("R13 flag after reset", {15'd0, flag}, 16'd0);
        check("R13 rst_req after reset", {15'd0, rst_req}, 16'd0);

        // R2 / R4: interval mode, clear, /64 on tick_sub
        wr(16'h5A1B);
        check("R4 clear bit reads 0, R2 layout", rd_data, 16'h6913);
        tick_aux = 1'b1; repeat (20) cyc(); tick_aux = 1'b0;   // R5: other tick ignored
        ticks(63, 1'b0);
        check("R6 /64 no expiry at tick 63", {15'd0, flag}, 16'd0);
        ticks(1, 1'b0);
        check("R6 /64 expiry at tick 64", {15'd0, flag}, 16'd1);
        check("R8 no reset request in interval mode", {15'd0, rst_req}, 16'd0);
        irq_en = 1'b1; glob_en = 1'b1; #1;
        check("R9 irq with both enables", {15'd0, irq}, 16'd1);
        glob_en = 1'b0; #1;
        check("R9 irq blocked by global enable", {15'd0, irq}, 16'd0);
        glob_en = 1'b1;
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        check("R10 ack clears flag in interval mode", {15'd0, flag}, 16'd0);
        ticks(63, 1'b0);
        check("R8 counting continues, no early second expiry", {15'd0, flag}, 16'd0);
        ticks(1, 1'b0);
        check("R8 second expiry one period later", {15'd0, flag}, 16'd1);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;

        // R3: hold
        wr(16'h5A9B);
        ticks(200, 1'b0);
        check("R3 held counter never expires", {15'd0, flag}, 16'd0);

        // R5: auxiliary tick
        wr(16'h5A1F);
        check("R5 readback with aux source", rd_data, 16'h6917);
        ticks(100, 1'b0);
        check("R5 subsystem tick ignored when aux selected", {15'd0, flag}, 16'd0);
        ticks(64, 1'b1);
        check("R5 aux tick counted", {15'd0, flag}, 16'd1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;

        // R1 / R11: bad key
        wr(16'h1234);
        check("R1 bad key raises reset request", {15'd0, rst_req}, 16'd1);
        check("R11 config back to default", rd_data, 16'h6900);
        cyc();
        check("R1 reset request lasts one cycle", {15'd0, rst_req}, 16'd0);

        // R7: supervision /512
        wr(16'h5A0A);
        check("R2 supervision readback", rd_data, 16'h6902);
        ticks(511, 1'b0);
        check("R7 no reset before tick 512", {15'd0, rst_req}, 16'd0);
        ticks(1, 1'b0);
        check("R7 reset request on expiry", {15'd0, rst_req}, 16'd1);
        check("R7 flag set on expiry", {15'd0, flag}, 16'd1);
        check("R11 default config after expiry", rd_data, 16'h6900);
        check("R9 no irq in supervision mode", {15'd0, irq}, 16'd0);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        check("R10 ack ignored in supervision mode", {15'd0, flag}, 16'd1);
        check("R11 flag kept after restart", {15'd0, flag}, 16'd1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        check("R10 software clear", {15'd0, flag}, 16'd0);

        // R12: pin configuration bits
        wr(16'h5A6B);
        check("R12 pin bits stored", rd_data, 16'h6963);
        ticks(63, 1'b0);
        check("R12 no early reset", {15'd0, rst_req}, 16'd0);
        ticks(1, 1'b0);
        check("R12 pin bits do not change period", {15'd0, rst_req}, 16'd1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;

        // R6: long periods
        wr(16'h5A19);
        ticks(8191, 1'b0);
        check("R6 /8192 no expiry at 8191", {15'd0, flag}, 16'd0);
        ticks(1, 1'b0);
        check("R6 /8192 expiry", {15'd0, flag}, 16'd1);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        wr(16'h5A18);
        ticks(32767, 1'b0);
        check("R6 /32768 no expiry at 32767", {15'd0, flag}, 16'd0);
        ticks(1, 1'b0);
        check("R6 /32768 expiry", {15'd0, flag}, 16'd1);

        // R13: reset clears flag
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        check("R13 reset clears flag", {15'd0, flag}, 16'd0);

        // random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            logic m_irq;
            m_irq = m_flag && m_cfg[4] && irq_en && glob_en;
            check("R1-model random compare rd", rd_data, {8'h69, m_cfg});
            check("R9-model random compare outputs", {13'd0, flag, irq, rst_req},
                  {13'd0, m_flag, m_irq, m_rreq});
            wr_en    = ($urandom % 12) == 0;
            wr_data  = {(($urandom % 8) == 0) ? 8'($urandom) : 8'h5A,
                        8'($urandom) | 8'h02};
            tick_sub = $urandom % 2;
            tick_aux = $urandom % 2;
            irq_en   = ($urandom % 4) != 0;
            glob_en  = ($urandom % 4) != 0;
            irq_ack  = ($urandom % 10) == 0;
            flag_clr = ($urandom % 16) == 0;
            cyc();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule